// File: doc/BRIEF.md
# Configurable Two-Level Sum-of-Products Logic Unit

This block is a small field-configurable logic unit. A wide AND plane builds product terms out of the primary inputs and out of the unit's own OR results. A fixed OR stage then gathers those terms into outputs, and each output has a polarity bit. The whole configuration arrives as a serial bit stream. A flag reports when a full image has been received, and the outputs stay low until that flag is set.

Each OR result is routed back into the AND plane before its polarity is applied. A single term can therefore use the complement of another output, which lets one output be built from another. The unit is meant for acyclic configurations only. A configuration in which outputs depend on each other in a loop is illegal, and its outputs are not defined by these requirements. With default parameters there are 4 inputs and 4 outputs, and each output has 4 terms, so a term has 8 literals and the image is 260 bits long.

Top module: `pal_logic_top`

## Requirements
- R1: While `cfgEn` is high and `cfgValid` is low, one bit from `cfgBit` is accepted at each rising clock edge. The first bit accepted becomes image bit 0. Term t occupies image bits [16t+15:16t]. Inside a term, literal j uses bits [2j+1:2j]. Literal j < 4 refers to `dataIn[j]`, and literal 4+o refers to OR result o. The polarity bit of output o is image bit 256+o.
- R2: `cfgValid` rises on the clock edge that accepts the 260th bit, and is low before that edge. Cycles in which `cfgEn` is low do not count towards the 260 bits.
- R3: While `cfgValid` is low, `dataOut` is all zeros.
- R4: Each literal has a 2-bit code. Code 00 ignores the literal, 01 requires the literal to be 1, 10 requires it to be 0, and 11 forces the whole term to 0.
- R5: A term whose literals are all coded 00 evaluates to 1.
- R6: OR result o is the OR of terms 4o to 4o+3 and of no other terms.
- R7: A feedback literal sees the OR result before polarity is applied. In any acyclic configuration, dependency chains up to 4 outputs deep settle to their correct values with no clock edge.
- R8: When the polarity bit of an output is 1, `dataOut` carries the complement of that output's OR result. When the bit is 0, it carries the OR result unchanged.
- R9: Once `cfgValid` is high, `cfgEn` and `cfgBit` have no effect. The image and `cfgValid` stay unchanged until reset.
- R10: When `rstN` is low, `cfgValid` is cleared and the bit count returns to zero. A complete new image must be loaded before the outputs leave zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration load |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEn | input | 1 | Accept one configuration bit this cycle |
| cfgBit | input | 1 | Serial configuration data |
| dataIn | input | 4 | Primary logic inputs |
| dataOut | output | 4 | Logic outputs after polarity, zero until configured |
| cfgValid | output | 1 | A full image has been loaded |

## Verification
The assertions check on every cycle that the outputs are zero while the unit is unconfigured and that `cfgValid` tracks an independent count of accepted bits. They also check that the flag never drops without a reset, and that the outputs cannot move while the inputs are steady once the image is frozen. The actual logic functions can only be shown by the bench's scenarios. These include the two-level expansion in which one output uses the complement of another, literal kill codes, all-don't-care terms, feedback taken before polarity, and a chain of two outputs. The bench also shows that extra configuration bits sent after loading change nothing.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Literal codes of the AND plane
  localparam logic [1:0] LIT_IGNORE = 2'b00;
  localparam logic [1:0] LIT_TRUE   = 2'b01;
  localparam logic [1:0] LIT_INV    = 2'b10;
  localparam logic [1:0] LIT_KILL   = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // take one serial bit into the image
    logic outEn;    // image complete, drive results
  } ctrlStrobes_t;

endpackage

// File: rtl/pal_plane_stage.sv
module pal_plane_stage
  import pal_pkg::*;
#(
  parameter int NUM_IN        = 4,
  parameter int NUM_OUT       = 4,
  parameter int TERMS_PER_OUT = 4
) (
  input  logic [NUM_OUT*TERMS_PER_OUT*2*(NUM_IN+NUM_OUT)-1:0] planeCfg,
  input  logic [NUM_IN-1:0]  dataIn,
  input  logic [NUM_OUT-1:0] fbIn,
  output logic [NUM_OUT-1:0] orOut
);
  localparam int NUM_LIT   = NUM_IN + NUM_OUT;
  localparam int TERM_W    = 2 * NUM_LIT;
  localparam int NUM_TERMS = NUM_OUT * TERMS_PER_OUT;

  logic [NUM_LIT-1:0]   litVal;
  logic [NUM_TERMS-1:0] termHit;

  assign litVal = {fbIn, dataIn};

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic hit;
    always_comb begin
      hit = 1'b1;
      for (int j = 0; j < NUM_LIT; j++) begin
        case (planeCfg[t*TERM_W + 2*j +: 2])
          LIT_TRUE: if (!litVal[j]) hit = 1'b0;
          LIT_INV:  if (litVal[j])  hit = 1'b0;
          LIT_KILL: hit = 1'b0;
          default:  ;
        endcase
      end
    end
    assign termHit[t] = hit;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_or
    assign orOut[o] = |termHit[o*TERMS_PER_OUT +: TERMS_PER_OUT];
  end

endmodule

// File: rtl/pal_cfg_ctrl.sv
module pal_cfg_ctrl
  import pal_pkg::*;
#(
  parameter int CFG_W = 260
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgEn,
  output ctrlStrobes_t strobes,
  output logic         cfgValid
);
  localparam int CNT_W = $clog2(CFG_W + 1);

  logic [CNT_W-1:0] bitCount;
  logic             validQ;

  assign strobes.shiftEn = cfgEn && !validQ;
  assign strobes.outEn   = validQ;
  assign cfgValid        = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      validQ   <= 1'b0;
    end else if (strobes.shiftEn) begin
      bitCount <= bitCount + 1'b1;
      if (bitCount == CNT_W'(CFG_W - 1)) validQ <= 1'b1;
    end
  end

endmodule

// File: rtl/pal_array_datapath.sv
module pal_array_datapath
  import pal_pkg::*;
#(
  parameter int NUM_IN        = 4,
  parameter int NUM_OUT       = 4,
  parameter int TERMS_PER_OUT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               cfgBit,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut
);
  localparam int NUM_LIT   = NUM_IN + NUM_OUT;
  localparam int TERM_W    = 2 * NUM_LIT;
  localparam int NUM_TERMS = NUM_OUT * TERMS_PER_OUT;
  localparam int PLANE_W   = NUM_TERMS * TERM_W;
  localparam int CFG_W     = PLANE_W + NUM_OUT;

  logic [CFG_W-1:0]   cfgImage;
  logic [NUM_OUT-1:0] polarity;
  logic [NUM_OUT-1:0] rawOr;

  // First bit shifted in ends at image bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfgImage <= '0;
    else if (strobes.shiftEn) cfgImage <= {cfgBit, cfgImage[CFG_W-1:1]};
  end

  // Feedback unrolled into NUM_OUT copies of the plane, each fed by the
  // previous copy; acyclic chains settle within NUM_OUT copies.
  for (genvar s = 0; s < NUM_OUT; s++) begin : g_stage
    logic [NUM_OUT-1:0] fb;
    logic [NUM_OUT-1:0] res;
    if (s == 0) begin : g_first
      assign fb = '0;
    end else begin : g_next
      assign fb = g_stage[s-1].res;
    end
    pal_plane_stage #(
      .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .TERMS_PER_OUT(TERMS_PER_OUT)
    ) plane_i (
      .planeCfg(cfgImage[PLANE_W-1:0]),
      .dataIn  (dataIn),
      .fbIn    (fb),
      .orOut   (res)
    );
  end

  assign rawOr    = g_stage[NUM_OUT-1].res;
  assign polarity = cfgImage[PLANE_W +: NUM_OUT];
  assign dataOut  = strobes.outEn ? (rawOr ^ polarity) : '0;

endmodule

// File: rtl/pal_logic_top.sv
module pal_logic_top
  import pal_pkg::*;
#(
  parameter int NUM_IN        = 4,
  parameter int NUM_OUT       = 4,
  parameter int TERMS_PER_OUT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEn,
  input  logic               cfgBit,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut,
  output logic               cfgValid
);
  localparam int CFG_W = NUM_OUT * TERMS_PER_OUT * 2 * (NUM_IN + NUM_OUT) + NUM_OUT;

  ctrlStrobes_t strobes;

  pal_cfg_ctrl #(.CFG_W(CFG_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfgEn   (cfgEn),
    .strobes (strobes),
    .cfgValid(cfgValid)
  );

  pal_array_datapath #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .TERMS_PER_OUT(TERMS_PER_OUT)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .cfgBit (cfgBit),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/pal_logic_checker.sv
module pal_logic_checker #(
  parameter int NUM_IN        = 4,
  parameter int NUM_OUT       = 4,
  parameter int TERMS_PER_OUT = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgEn,
  input logic               cfgBit,
  input logic [NUM_IN-1:0]  dataIn,
  input logic [NUM_OUT-1:0] dataOut,
  input logic               cfgValid
);
  localparam int CFG_W = NUM_OUT * TERMS_PER_OUT * 2 * (NUM_IN + NUM_OUT) + NUM_OUT;
  localparam int CNT_W = $clog2(CFG_W + 1);

  logic [CNT_W-1:0] seenBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenBits <= '0;
    else if (cfgEn && seenBits < CNT_W'(CFG_W)) seenBits <= seenBits + 1'b1;
  end

  AST_OUT_QUIET_UNTIL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> dataOut == '0) else $error("outputs active before configuration"); // R3

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (seenBits < CNT_W'(CFG_W)) |-> !cfgValid) else $error("valid before full image"); // R2

  AST_VALID_ON_FULL_IMAGE: assert property (@(posedge clk) disable iff (!rstN)
    (seenBits == CNT_W'(CFG_W)) |-> cfgValid) else $error("valid missing after full image"); // R2

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid) else $error("valid dropped without reset"); // R9

  AST_FROZEN_AFTER_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && $past(cfgValid) && $stable(dataIn)) |-> $stable(dataOut))
    else $error("outputs moved with steady inputs after load"); // R9

endmodule

bind pal_logic_top pal_logic_checker #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .TERMS_PER_OUT(TERMS_PER_OUT)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cfgEn   (cfgEn),
  .cfgBit  (cfgBit),
  .dataIn  (dataIn),
  .dataOut (dataOut),
  .cfgValid(cfgValid)
);

// File: tb/pal_logic_top_tb_top.sv
module pal_logic_top_tb_top;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int TPO = 4;
  localparam int TW = 2 * (NI + NO);
  localparam int PLANE = NO * TPO * TW;
  localparam int TOTAL = PLANE + NO;

  localparam logic [1:0] C_IGN = 2'b00, C_TRU = 2'b01, C_INV = 2'b10, C_KIL = 2'b11;

  // Config A expected outputs, index = {D,C,B,A}:
  // out0 = AD+BD+A'B'+C', out1 = AB+CD+out0', out2 = (AB)', out3 = out1 & C
  localparam logic [3:0] EXP_A [16] = '{4'h5, 4'h5, 4'h5, 4'h3, 4'h5, 4'hE, 4'hE, 4'hA,
                                        4'h5, 4'h5, 4'h5, 4'h3, 4'hF, 4'hF, 4'hF, 4'hB};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEn = 1'b0;
  logic cfgBit = 1'b0;
  logic [NI-1:0] dataIn = '0;
  logic [NO-1:0] dataOut;
  logic cfgValid;

  logic [TOTAL-1:0] img;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pal_logic_top dut_i (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgBit(cfgBit),
    .dataIn(dataIn), .dataOut(dataOut), .cfgValid(cfgValid)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic imgClear();
    img = '1;
    img[PLANE +: NO] = '0;
  endtask

  task automatic openTerm(input int t);
    img[t*TW +: TW] = '0;
  endtask

  task automatic setLit(input int t, input int j, input logic [1:0] code);
    img[t*TW + 2*j +: 2] = code;
  endtask

  task automatic shiftBits(input int first, input int count);
    for (int i = first; i < first + count; i++) begin
      @(negedge clk);
      cfgEn = 1'b1;
      cfgBit = img[i];
    end
    @(negedge clk);
    cfgEn = 1'b0;
  endtask

  task automatic applyIn(input logic [NI-1:0] v);
    @(negedge clk);
    dataIn = v;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Config A: literals 0..3 = A,B,C,D; literal 4+o = OR result o
    imgClear();
    openTerm(0);  setLit(0, 0, C_TRU);  setLit(0, 3, C_TRU);
    openTerm(1);  setLit(1, 1, C_TRU);  setLit(1, 3, C_TRU);
    openTerm(2);  setLit(2, 0, C_INV);  setLit(2, 1, C_INV);
    openTerm(3);  setLit(3, 2, C_INV);
    openTerm(4);  setLit(4, 0, C_TRU);  setLit(4, 1, C_TRU);
    openTerm(5);  setLit(5, 2, C_TRU);  setLit(5, 3, C_TRU);
    openTerm(6);  setLit(6, 4, C_INV);
    openTerm(8);  setLit(8, 0, C_TRU);  setLit(8, 1, C_TRU);
    img[PLANE + 2] = 1'b1;
    openTerm(12); setLit(12, 5, C_TRU); setLit(12, 2, C_TRU);
    openTerm(13); setLit(13, 0, C_KIL); setLit(13, 1, C_TRU);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    applyIn(4'hF);
    check(cfgValid, 0, "R10 reset valid");
    check(dataOut, 0, "R3 reset outputs");

    shiftBits(0, TOTAL - 1);
    repeat (5) @(negedge clk);
    #1;
    check(cfgValid, 0, "R2 one bit short, idle cycles not counted");
    check(dataOut, 0, "R3 outputs zero during load");

    shiftBits(TOTAL - 1, 1);
    #1;
    check(cfgValid, 1, "R2 valid after last bit");

    // Table walk: R1 R4 R6 R7 R8
    for (int v = 0; v < 16; v++) begin
      applyIn(NI'(v));
      check(dataOut, EXP_A[v], "R1 R4 R6 R7 R8 config A table");
    end

    // R9: extra bits after valid change nothing
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      cfgEn = 1'b1;
      cfgBit = i[0] ^ i[3];
    end
    @(negedge clk);
    cfgEn = 1'b0;
    #1;
    check(cfgValid, 1, "R9 valid held");
    for (int v = 0; v < 16; v += 5) begin
      applyIn(NI'(v));
      check(dataOut, EXP_A[v], "R9 image frozen");
    end

    // R10: reset drops valid and outputs
    doReset();
    applyIn(4'h5);
    check(cfgValid, 0, "R10 valid cleared");
    check(dataOut, 0, "R10 R3 outputs zero after reset");

    // Config B: out0 all-ignore term (R5), out2 inverted empty OR (R8),
    // out3 = OR2 before polarity (=0) | (OR0 & A')  (R7)
    imgClear();
    openTerm(0);
    img[PLANE + 2] = 1'b1;
    openTerm(12); setLit(12, 6, C_TRU);
    openTerm(13); setLit(13, 4, C_TRU); setLit(13, 0, C_INV);
    shiftBits(0, TOTAL);
    #1;
    check(cfgValid, 1, "R2 R10 reload valid");
    for (int v = 0; v < 16; v++) begin
      applyIn(NI'(v));
      check(dataOut, v[0] ? 4'h5 : 4'hD, "R5 R7 R8 config B");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule